// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block copies a run of bytes from a small internal staging buffer into a byte-wide parallel EEPROM. Software or a host-side engine first fills the buffer through its write port. It then presents a start offset and a byte count, and pulses `start`. For every byte the sequencer asks an external address shift loader to load the target address and waits for that loader to acknowledge. It then drives the byte onto the data bus, holds it for a setup time, pulses the active-low write strobe for a fixed width and keeps the bus steady for a hold time. Bytes are grouped into pages of `PAGE_BYTES`, counted from the first byte of the buffer rather than from absolute memory page boundaries. After each page there is a long programming wait, including after the last page.

Before the first byte, the data bus direction is switched to output while the level-shifter enable is low. After the last page wait, the direction is switched back to input in the same way. The memory's output enable stays inactive (high) and its chip enable stays active (low) throughout. A busy lock is held from the accepted start until completion. A start is rejected if it arrives while the lock is held, while the reader holds its lock (`rd_lock`), or with a count larger than the buffer. The pending count is visible while busy and is zero when completion is signalled.

States and transitions: IDLE goes to DIR_OUT on an accepted start with a non-zero count, or straight to FINISH on an accepted start with count zero. DIR_OUT goes to ADDR_REQ when the turn time elapses. ADDR_REQ always goes to ADDR_WAIT. ADDR_WAIT goes to SETUP on the loader acknowledge. SETUP goes to STROBE, and STROBE goes to HOLD, each when its time elapses. When the hold time elapses, HOLD goes to PAGE_WAIT if the byte closed a page or was the last byte; otherwise it goes to ADDR_REQ. When the wait elapses, PAGE_WAIT goes to DIR_IN if all bytes are written, or to ADDR_REQ if not. DIR_IN goes to FINISH when the turn time elapses. FINISH always returns to IDLE.

Top module: `eeprom_page_writer`

## Requirements
- R1: An accepted start (issued in IDLE, with `rd_lock` low and count at most `BUF_BYTES`) raises `busy_lock` in the next cycle. `busy_lock` stays high through the cycle in which `done` is high and is low in the cycle after.
- R2: A start is rejected if `busy_lock` is high, if `rd_lock` is high, or if the count exceeds `BUF_BYTES`. `start_rej` is high for one cycle, in the cycle after such a start, and the rejected start causes no write strobe and no change to the running transfer.
- R3: Byte i of a transfer is written to address (offset + i) modulo 2^AW, with the data taken from buffer entry i. Exactly `count` write strobes are issued per transfer.
- R4: Each byte begins with `addr_ld` high for exactly one cycle. `mem_we_n` first goes low SETUP_CYC+1 cycles after the cycle in which `addr_done` is high, where SETUP_CYC = ceil(SETUP_NS / CLK_PERIOD_NS).
- R5: `mem_we_n` stays low for exactly STROBE_CYC = ceil(STROBE_NS / CLK_PERIOD_NS) cycles, and `bus_dout` is stable while it is low.
- R6: Within a page, the next `addr_ld` comes HOLD_CYC = ceil(HOLD_NS / CLK_PERIOD_NS) cycles after `mem_we_n` returns high.
- R7: After byte i is written, where (i+1) is a multiple of 64 (`PAGE_BYTES`) and byte i is not the last byte, the next `addr_ld` comes HOLD_CYC + WAIT_CYC cycles after `mem_we_n` rises, where WAIT_CYC = ceil(PAGE_WAIT_NS / CLK_PERIOD_NS).
- R8: After the last byte, `done` is high for one cycle, HOLD_CYC + WAIT_CYC + DIR_CYC cycles after `mem_we_n` rises, where DIR_CYC = ceil(DIR_NS / CLK_PERIOD_NS).
- R9: `mem_oe_n` is always 1 and `mem_ce_n` is always 0.
- R10: `bus_dir_out` (1 = output) changes only in cycles where `lvl_en` is low. Each low period of `lvl_en` lasts exactly DIR_CYC cycles. During every strobe, `bus_dir_out` and `lvl_en` are both 1.
- R11: While a transfer is writing, `pend_cnt` equals its count. In the cycle where `done` is high, `pend_cnt` is 0.
- R12: An accepted start with count 0 gives `done` and `busy_lock` high in the next cycle, with no strobe and no direction change.
- R13: Buffer writes made while `busy_lock` is high are ignored. Writes made while idle are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe for a write run |
| start_offset | input | AW | Memory address of the first byte |
| start_count | input | CW | Number of bytes to write |
| rd_lock | input | 1 | Reader holds the shared lock |
| buf_we | input | 1 | Staging buffer write enable |
| buf_waddr | input | IW | Staging buffer write index |
| buf_wdata | input | DW | Staging buffer write data |
| addr_ld | output | 1 | Request to the address shift loader |
| addr_val | output | AW | Address to be loaded |
| addr_done | input | 1 | Loader acknowledge |
| bus_dout | output | DW | Data driven toward the memory |
| bus_dir_out | output | 1 | Bus direction, 1 = output |
| lvl_en | output | 1 | Level-shifter enable |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| busy_lock | output | 1 | Shared lock held by the writer |
| done | output | 1 | One-cycle completion pulse |
| start_rej | output | 1 | One-cycle rejected-start pulse |
| pend_cnt | output | CW | Bytes pending in the current run |

## Verification
The bench runs a 130-byte transfer, which ends in a two-byte partial page. A design that aligned pages to absolute addresses, or that skipped the wait after a short last page, would place its long gaps in the wrong positions. A transfer that starts near the top of the address space catches offset arithmetic that does not wrap. An exactly full page checks that the final byte takes the completion path rather than inserting a second wait. The address loader acknowledges after 1, 2 or 3 cycles, so a sequencer that strobes on a fixed delay instead of the acknowledge would be caught. The bench also issues starts while busy, while the reader holds the lock, and with an oversize count, and it writes to the buffer during a transfer. A design that failed to gate any of these would emit extra strobes or write stale data.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DIR_OUT,
        ST_ADDR_REQ,
        ST_ADDR_WAIT,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_PAGE_WAIT,
        ST_DIR_IN,
        ST_FINISH
    } wr_state_e;

    // Whole clock cycles covering a time span, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
        int unsigned c;
        c = (ns + per_ns - 1) / per_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eepw_buffer.sv
module eepw_buffer #(
    parameter int DEPTH = 512,
    parameter int IW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/eepw_timer.sv
module eepw_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
    import eepw_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int CW         = 10,
    parameter int IW         = 9,
    parameter int PW         = 6,
    parameter int BUF_BYTES  = 512,
    parameter int TW         = 20,
    parameter int SETUP_CYC  = 3,
    parameter int STROBE_CYC = 8,
    parameter int HOLD_CYC   = 3,
    parameter int DIR_CYC    = 2,
    parameter int WAIT_CYC   = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_offset,
    input  logic [CW-1:0] start_count,
    input  logic          rd_lock,
    input  logic          addr_done,
    input  logic          tmr_zero,
    input  logic [DW-1:0] buf_rdata,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic [IW-1:0] rd_idx,
    output logic          addr_ld,
    output logic [AW-1:0] addr_val,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dir_out,
    output logic          lvl_en,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_ce_n,
    output logic          busy,
    output logic          done,
    output logic          start_rej,
    output logic [CW-1:0] pend_cnt
);

    wr_state_e     state, nxt;
    logic [AW-1:0] off_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx_q;
    logic [DW-1:0] data_q;
    logic          rej_q;

    logic accept;
    logic last_byte;
    logic page_end;
    logic all_sent;

    assign accept    = (state == ST_IDLE) && start && !rd_lock
                       && (start_count <= CW'(BUF_BYTES));
    assign last_byte = (idx_q == (cnt_q - CW'(1)));
    assign page_end  = &idx_q[PW-1:0];
    assign all_sent  = (idx_q == cnt_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (start_count == '0) begin
                        nxt = ST_FINISH;
                    end else begin
                        nxt      = ST_DIR_OUT;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(DIR_CYC - 1);
                    end
                end
            end
            ST_DIR_OUT: begin
                if (tmr_zero) nxt = ST_ADDR_REQ;
            end
            ST_ADDR_REQ: begin
                nxt = ST_ADDR_WAIT;
            end
            ST_ADDR_WAIT: begin
                if (addr_done) begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    nxt      = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STROBE_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    nxt      = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    if (last_byte || page_end) begin
                        nxt      = ST_PAGE_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(WAIT_CYC - 1);
                    end else begin
                        nxt = ST_ADDR_REQ;
                    end
                end
            end
            ST_PAGE_WAIT: begin
                if (tmr_zero) begin
                    if (all_sent) begin
                        nxt      = ST_DIR_IN;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(DIR_CYC - 1);
                    end else begin
                        nxt = ST_ADDR_REQ;
                    end
                end
            end
            ST_DIR_IN: begin
                if (tmr_zero) nxt = ST_FINISH;
            end
            ST_FINISH: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Run context: offset, count, byte index, latched data, reject flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
            rej_q  <= 1'b0;
        end else begin
            rej_q <= start && !accept;
            if (accept) begin
                off_q  <= start_offset;
                cnt_q  <= start_count;
                idx_q  <= '0;
                data_q <= '0;
            end
            if ((state == ST_ADDR_WAIT) && addr_done) begin
                data_q <= buf_rdata;
            end
            if ((state == ST_HOLD) && tmr_zero) begin
                idx_q <= idx_q + CW'(1);
            end
            if (nxt == ST_FINISH) begin
                cnt_q <= '0;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        addr_ld     = 1'b0;
        mem_we_n    = 1'b1;
        lvl_en      = 1'b1;
        bus_dir_out = 1'b1;
        busy        = 1'b1;
        done        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                bus_dir_out = 1'b0;
                busy        = 1'b0;
            end
            ST_DIR_OUT:   lvl_en   = 1'b0;
            ST_ADDR_REQ:  addr_ld  = 1'b1;
            ST_ADDR_WAIT: ;
            ST_SETUP:     ;
            ST_STROBE:    mem_we_n = 1'b0;
            ST_HOLD:      ;
            ST_PAGE_WAIT: ;
            ST_DIR_IN: begin
                lvl_en      = 1'b0;
                bus_dir_out = 1'b0;
            end
            ST_FINISH: begin
                bus_dir_out = 1'b0;
                done        = 1'b1;
            end
            default: begin
                bus_dir_out = 1'b0;
                busy        = 1'b0;
            end
        endcase
    end

    assign mem_oe_n  = 1'b1;
    assign mem_ce_n  = 1'b0;
    assign addr_val  = off_q + AW'(idx_q);
    assign bus_dout  = data_q;
    assign rd_idx    = idx_q[IW-1:0];
    assign pend_cnt  = cnt_q;
    assign start_rej = rej_q;

    // R5
    strobe_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(bus_dout));

    // R10
    dir_turn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dir_out != $past(bus_dir_out)) |-> !lvl_en);

    // R10
    strobe_bus_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (bus_dir_out && lvl_en));

    // R4
    addr_ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> !addr_ld);

    // R1
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R2
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rej |-> $past(start));

    // R11
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend_cnt == '0));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int AW            = 16,
    parameter int DW            = 8,
    parameter int BUF_BYTES     = 512,
    parameter int PAGE_BYTES    = 64,
    parameter int CLK_PERIOD_NS = 20,
    parameter int SETUP_NS      = 50,
    parameter int STROBE_NS     = 150,
    parameter int HOLD_NS       = 50,
    parameter int DIR_NS        = 40,
    parameter int PAGE_WAIT_NS  = 10_000_000,
    localparam int CW           = $clog2(BUF_BYTES + 1),
    localparam int IW           = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_offset,
    input  logic [CW-1:0] start_count,
    input  logic          rd_lock,
    input  logic          buf_we,
    input  logic [IW-1:0] buf_waddr,
    input  logic [DW-1:0] buf_wdata,
    output logic          addr_ld,
    output logic [AW-1:0] addr_val,
    input  logic          addr_done,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dir_out,
    output logic          lvl_en,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_ce_n,
    output logic          busy_lock,
    output logic          done,
    output logic          start_rej,
    output logic [CW-1:0] pend_cnt
);

    localparam int PW         = $clog2(PAGE_BYTES);
    localparam int SETUP_CYC  = int'(ns_to_cyc(SETUP_NS, CLK_PERIOD_NS));
    localparam int STROBE_CYC = int'(ns_to_cyc(STROBE_NS, CLK_PERIOD_NS));
    localparam int HOLD_CYC   = int'(ns_to_cyc(HOLD_NS, CLK_PERIOD_NS));
    localparam int DIR_CYC    = int'(ns_to_cyc(DIR_NS, CLK_PERIOD_NS));
    localparam int WAIT_CYC   = int'(ns_to_cyc(PAGE_WAIT_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC    = int'(max_of(max_of(WAIT_CYC, STROBE_CYC),
                                            max_of(max_of(SETUP_CYC, HOLD_CYC), DIR_CYC)));
    localparam int TW         = $clog2(MAX_CYC + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic [IW-1:0] rd_idx;
    logic [DW-1:0] buf_rdata;
    logic          busy_w;

    eepw_buffer #(
        .DEPTH (BUF_BYTES),
        .IW    (IW),
        .DW    (DW)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we && !busy_w),
        .wr_addr (buf_waddr),
        .wr_data (buf_wdata),
        .rd_addr (rd_idx),
        .rd_data (buf_rdata)
    );

    eepw_timer #(
        .TW (TW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    eepw_ctrl #(
        .AW         (AW),
        .DW         (DW),
        .CW         (CW),
        .IW         (IW),
        .PW         (PW),
        .BUF_BYTES  (BUF_BYTES),
        .TW         (TW),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .DIR_CYC    (DIR_CYC),
        .WAIT_CYC   (WAIT_CYC)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_offset (start_offset),
        .start_count  (start_count),
        .rd_lock      (rd_lock),
        .addr_done    (addr_done),
        .tmr_zero     (tmr_zero),
        .buf_rdata    (buf_rdata),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .rd_idx       (rd_idx),
        .addr_ld      (addr_ld),
        .addr_val     (addr_val),
        .bus_dout     (bus_dout),
        .bus_dir_out  (bus_dir_out),
        .lvl_en       (lvl_en),
        .mem_we_n     (mem_we_n),
        .mem_oe_n     (mem_oe_n),
        .mem_ce_n     (mem_ce_n),
        .busy         (busy_w),
        .done         (done),
        .start_rej    (start_rej),
        .pend_cnt     (pend_cnt)
    );

    assign busy_lock = busy_w;

endmodule

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;

    localparam int AW   = 16;
    localparam int BUFB = 256;
    localparam int PAGE = 64;
    localparam int CWB  = 9;
    localparam int IWB  = 8;
    localparam int SET  = 3;    // 50 ns at 20 ns
    localparam int STB  = 8;    // 150 ns
    localparam int HLD  = 3;    // 50 ns
    localparam int DIRC = 2;    // 40 ns
    localparam int WT   = 200;  // 4000 ns

    logic           clk, rst_n, start, rd_lock, buf_we, addr_done;
    logic [AW-1:0]  start_offset;
    logic [CWB-1:0] start_count;
    logic [IWB-1:0] buf_waddr;
    logic [7:0]     buf_wdata;
    logic           addr_ld, bus_dir_out, lvl_en, mem_we_n, mem_oe_n, mem_ce_n;
    logic           busy_lock, done, start_rej;
    logic [AW-1:0]  addr_val;
    logic [7:0]     bus_dout;
    logic [CWB-1:0] pend_cnt;

    eeprom_page_writer #(
        .AW (AW), .DW (8), .BUF_BYTES (BUFB), .PAGE_BYTES (PAGE),
        .CLK_PERIOD_NS (20), .SETUP_NS (50), .STROBE_NS (150), .HOLD_NS (50),
        .DIR_NS (40), .PAGE_WAIT_NS (4000)
    ) u_eeprom_page_writer (
        .clk (clk), .rst_n (rst_n), .start (start), .start_offset (start_offset),
        .start_count (start_count), .rd_lock (rd_lock), .buf_we (buf_we),
        .buf_waddr (buf_waddr), .buf_wdata (buf_wdata), .addr_ld (addr_ld),
        .addr_val (addr_val), .addr_done (addr_done), .bus_dout (bus_dout),
        .bus_dir_out (bus_dir_out), .lvl_en (lvl_en), .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n), .mem_ce_n (mem_ce_n), .busy_lock (busy_lock),
        .done (done), .start_rej (start_rej), .pend_cnt (pend_cnt)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference state
    logic [7:0]  bmem [BUFB];
    logic [15:0] qa [$];
    logic [7:0]  qd [$];
    int cur_count = 0;
    int idx_seen = 0;
    int strobes_total = 0;
    int done_seen = 0;
    int cyc = 0;
    int done_cyc = 0;
    int fall_cyc = 0;
    int rise_cyc = 0;
    int gap_kind = 0;   // 0 none, 1 in page, 2 page end, 3 last byte
    int lvl_low_run = 0;
    int ld_cnt = 0;
    int lat_sel = 0;
    logic [7:0] fall_data;
    logic prev_we, prev_dir, prev_lvl;

    // Cycle monitor and address loader model
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WD", "watchdog expired", cyc, 150000);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
        if (!rst_n) begin
            prev_we = 1'b1; prev_dir = 1'b0; prev_lvl = 1'b1;
            ld_cnt = 0; addr_done = 1'b0; lvl_low_run = 0;
        end else begin
            addr_done = 1'b0;
            if (ld_cnt > 0) begin
                ld_cnt--;
                if (ld_cnt == 0) begin
                    addr_done = 1'b1;
                    done_cyc = cyc;
                end
            end
            // R9
            chk(mem_oe_n == 1'b1 && mem_ce_n == 1'b0, "R9", "oe_n/ce_n",
                {mem_oe_n, mem_ce_n}, 2'b10);
            // R10
            if (bus_dir_out != prev_dir)
                chk(!lvl_en, "R10", "direction changed with lvl_en high", lvl_en, 0);
            if (!lvl_en) lvl_low_run++;
            else if (!prev_lvl) begin
                chk(lvl_low_run == DIRC, "R10", "lvl_en low length", lvl_low_run, DIRC);
                lvl_low_run = 0;
            end
            if (addr_ld) begin
                if (gap_kind == 1)
                    chk(cyc - rise_cyc == HLD, "R6", "hold gap", cyc - rise_cyc, HLD);
                else if (gap_kind == 2)
                    chk(cyc - rise_cyc == HLD + WT, "R7", "page wait gap", cyc - rise_cyc, HLD + WT);
                else if (gap_kind == 3)
                    chk(1'b0, "R3", "address load after last byte", 1, 0);
                gap_kind = 0;
                ld_cnt = 1 + (lat_sel % 3);
                lat_sel++;
            end
            if (!mem_we_n && prev_we) begin
                chk(qa.size() > 0, "R3", "strobe with nothing pending", qa.size(), 1);
                if (qa.size() > 0) begin
                    logic [15:0] ea;
                    logic [7:0]  ed;
                    ea = qa.pop_front();
                    ed = qd.pop_front();
                    chk(addr_val == ea, "R3", "address", addr_val, ea);
                    chk(bus_dout == ed, "R3", "data", bus_dout, ed);
                end
                chk(cyc - done_cyc == SET + 1, "R4", "setup after load ack", cyc - done_cyc, SET + 1);
                chk(bus_dir_out && lvl_en, "R10", "bus not driven at strobe", {bus_dir_out, lvl_en}, 2'b11);
                chk(pend_cnt == cur_count, "R11", "pending count", pend_cnt, cur_count);
                fall_cyc = cyc;
                fall_data = bus_dout;
                idx_seen++;
                strobes_total++;
            end else if (!mem_we_n && !prev_we) begin
                chk(bus_dout == fall_data, "R5", "data moved during strobe", bus_dout, fall_data);
            end
            if (mem_we_n && !prev_we) begin
                chk(cyc - fall_cyc == STB, "R5", "strobe width", cyc - fall_cyc, STB);
                rise_cyc = cyc;
                if (idx_seen == cur_count) gap_kind = 3;
                else if (idx_seen % PAGE == 0) gap_kind = 2;
                else gap_kind = 1;
            end
            if (done) begin
                done_seen++;
                if (gap_kind == 3)
                    chk(cyc - rise_cyc == HLD + WT + DIRC, "R8", "completion gap",
                        cyc - rise_cyc, HLD + WT + DIRC);
                gap_kind = 0;
                chk(pend_cnt == 0, "R11", "pending not cleared at done", pend_cnt, 0);
                chk(qa.size() == 0, "R3", "bytes left unwritten", qa.size(), 0);
                chk(busy_lock, "R1", "busy low during done", busy_lock, 1);
            end
            prev_we = mem_we_n; prev_dir = bus_dir_out; prev_lvl = lvl_en;
        end
    end

    task automatic fill(input int a, input logic [7:0] d, input bit taken);
        @(negedge clk);
        buf_we = 1'b1; buf_waddr = IWB'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
        if (taken) bmem[a] = d;
    endtask

    task automatic launch(input logic [15:0] off, input int cnt, input bit ok, input string req);
        if (ok) begin
            cur_count = cnt; idx_seen = 0; gap_kind = 0;
            for (int i = 0; i < cnt; i++) begin
                qa.push_back(off + 16'(i));
                qd.push_back(bmem[i]);
            end
        end
        @(negedge clk);
        start = 1'b1; start_offset = off; start_count = CWB'(cnt);
        @(negedge clk);
        start = 1'b0;
        if (ok) begin
            chk(busy_lock == 1'b1, req, "busy after accepted start", busy_lock, 1);
            chk(start_rej == 1'b0, req, "accepted start flagged", start_rej, 0);
        end else begin
            chk(start_rej == 1'b1, req, "reject pulse", start_rej, 1);
        end
    endtask

    task automatic wait_done();
        int n0;
        n0 = done_seen;
        while (done_seen == n0) @(negedge clk);
        @(negedge clk);
        chk(busy_lock == 1'b0, "R1", "busy after done", busy_lock, 0);
    endtask

    initial begin
        int s0;
        rst_n = 1'b0; start = 1'b0; rd_lock = 1'b0; buf_we = 1'b0; addr_done = 1'b0;
        start_offset = '0; start_count = '0; buf_waddr = '0; buf_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_we_n && !busy_lock && !done && lvl_en && !bus_dir_out && !addr_ld
            && !start_rej && pend_cnt == 0, "R1", "reset state",
            {mem_we_n, busy_lock, done, lvl_en, bus_dir_out, addr_ld, start_rej}, 7'b1001000);

        for (int i = 0; i < BUFB; i++) fill(i, 8'((i * 37 + 5) & 255), 1'b1);

        // R7 two full pages plus a partial page
        launch(16'h1F00, 130, 1'b1, "R1");
        wait_done();
        chk(strobes_total == 130, "R3", "strobe count", strobes_total, 130);

        // R3 wrapping addresses; R2 start while busy; R13 write while busy
        launch(16'hFFF0, 20, 1'b1, "R3");
        repeat (5) @(negedge clk);
        launch(16'h0000, 5, 1'b0, "R2");
        fill(0, 8'hAA, 1'b0);
        wait_done();
        chk(strobes_total == 150, "R2", "strobe count after reject", strobes_total, 150);

        // R8 exactly one page
        launch(16'h0100, 64, 1'b1, "R8");
        wait_done();

        // R2 reader holds lock
        s0 = strobes_total;
        rd_lock = 1'b1;
        launch(16'h0000, 4, 1'b0, "R2");
        repeat (3) @(negedge clk);
        chk(!busy_lock && strobes_total == s0, "R2", "lock-blocked start took effect",
            busy_lock, 0);
        rd_lock = 1'b0;

        // R2 oversize count
        launch(16'h0000, BUFB + 1, 1'b0, "R2");
        repeat (3) @(negedge clk);
        chk(!busy_lock, "R2", "oversize start took effect", busy_lock, 0);

        // R12 zero count
        s0 = strobes_total;
        launch(16'h0040, 0, 1'b1, "R12");
        chk(done == 1'b1, "R12", "done one cycle after zero-count start", done, 1);
        @(negedge clk);
        chk(!busy_lock && strobes_total == s0 && !bus_dir_out, "R12", "zero-count side effects",
            strobes_total, s0);

        // R13 buffer entry 0 must still hold its idle-time value
        launch(16'h0005, 1, 1'b1, "R13");
        wait_done();

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule